// File: doc/BRIEF.md
# Bitstream Deglitch and Switching Window Gate

This block sits on the receive side of an isolated single-bit modulator link, between the data line and the decimation filter. It samples the line once per modulator clock. Short pulses are treated as interference: a new level reaches the output only after it has been present for a programmable number of consecutive samples. Pulses that are too short are discarded and counted. A separate monitor raises a flag when the raw line has held one value for longer than a programmable limit. Such a run is impossible for a working modulator and points to overload.

The block also watches an external switching-event input. Every rising or falling edge on that input opens a blanking window. The window begins a programmable delay after the edge and lasts a programmable length. While the window is open, the output repeats the bit it last delivered. A per-bit disturbance flag marks every bit that is being held, whether it is held for blanking or because a level change is still being qualified. The decimator can use that flag to mark the affected samples invalid. The glitch counter is 16 bits wide, stops at its maximum value and is cleared by a strobe.

Top module: `bitstream_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bit_out`, `bit_flag` and `sat_flag` are 0 and `glitch_count` is 0.
- R2: Let N be `cfg_min_width` (1 to 7; a value of 0 behaves as 1). A new level on `bit_in` is sampled at N consecutive rising edges. `bit_out` takes the new level right after the N-th of those edges, provided no blanking window is open.
- R3: While a level change is being qualified (sampled for at least 1 and fewer than N edges), `bit_out` keeps the previous level and `bit_flag` is 1.
- R4: A pulse of fewer than N samples never reaches `bit_out`. `glitch_count` goes up by exactly 1 at the edge where the line is first sampled back at the accepted level. Pulses of at least N samples do not change the count.
- R5: `glitch_count` saturates at 65535 and stays there as further glitches arrive.
- R6: `cnt_clear` sampled high sets `glitch_count` to 0 at that edge. The clear wins over a glitch counted at the same edge.
- R7: Let k be the number of consecutive edges at which the raw `bit_in` has been sampled at the same value. `sat_flag` is 1 exactly when k exceeds `cfg_max_run`. A change of value restarts k at 1.
- R8: Let E be the edge at which a change of `sw_evt` is first sampled, D be `cfg_blank_delay` and L be `cfg_blank_len`. After edges E+D through E+D+L-1, `bit_flag` is 1. If L is 0, no window opens.
- R9: While a window is open, `bit_out` repeats the bit it delivered just before the window. Once the window closes, the filtered level appears again.
- R10: A `sw_evt` edge that arrives while a delay or a window is running restarts the sequence from that edge, delay first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Raw bitstream from the isolation barrier |
| sw_evt | input | 1 | Switching-event signal; both edges open a window |
| cfg_min_width | input | 3 | Minimum legal pulse width in clocks |
| cfg_max_run | input | RUN_W (8) | Longest legal run of identical raw bits |
| cfg_blank_delay | input | DLY_W (8) | Clocks from the event edge to the start of the window |
| cfg_blank_len | input | LEN_W (8) | Window length in clocks |
| cnt_clear | input | 1 | Clear strobe for the glitch counter |
| bit_out | output | 1 | Cleaned bitstream to the decimator |
| bit_flag | output | 1 | Disturbance flag for the current output bit |
| sat_flag | output | 1 | Over-long run (overload) indicator |
| glitch_count | output | CNT_W (16) | Saturating count of rejected pulses |

## Verification
Two functions can act on the same output bit: the pulse-width qualifier and the blanking window. The bench provokes this by toggling `sw_evt` with zero delay in the same cycle that `bit_in` changes level, while the minimum width is set to 3. During the window, the output must hold the old bit with the flag set. The new level must appear on the first edge after the window closes, which is also the edge that finishes qualification. A second overlap is a clear strobe placed on the very edge where a rejected pulse would be counted. That case is judged by the counter reading 0 afterwards and then 1 after the next glitch.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

    localparam int MINW_W = 3;

    typedef enum logic [1:0] {
        BLK_IDLE   = 2'd0,
        BLK_DELAY  = 2'd1,
        BLK_ACTIVE = 2'd2
    } blk_phase_e;

    typedef struct packed {
        logic level;    // accepted level
        logic pending;  // change under qualification
        logic reject;   // short pulse discarded this cycle
    } filt_out_t;

    // zero width is treated as one clock
    function automatic logic [MINW_W-1:0] eff_min_width(input logic [MINW_W-1:0] w);
        return (w == '0) ? MINW_W'(1) : w;
    endfunction

endpackage

// File: rtl/bsg_pulse_filter.sv
module bsg_pulse_filter
    import bsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [MINW_W-1:0] min_width,
    output filt_out_t         fout
);
    localparam int W1 = MINW_W + 1;

    logic              acc_q;
    logic [MINW_W-1:0] cnt_q;
    logic [W1-1:0]     cnt_inc;
    logic [W1-1:0]     limit;
    logic              agree;

    assign agree   = (din == acc_q);
    assign cnt_inc = W1'(cnt_q) + W1'(1);
    assign limit   = W1'(eff_min_width(min_width));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b0;
            cnt_q <= '0;
        end else if (agree) begin
            cnt_q <= '0;
        end else if (cnt_inc >= limit) begin
            acc_q <= din;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + MINW_W'(1);
        end
    end

    always_comb begin
        fout.level   = acc_q;
        fout.pending = (cnt_q != '0);
        fout.reject  = agree && (cnt_q != '0);
    end

endmodule

// File: rtl/bsg_run_monitor.sv
module bsg_run_monitor #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [RUN_W-1:0] max_run,
    output logic             sat
);
    logic             prev_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= din;
            if (run_q == '0 || din != prev_q) begin
                run_q <= RUN_W'(1);
            end else if (!(&run_q)) begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    assign sat = (run_q > max_run);

endmodule

// File: rtl/bsg_blank_timer.sv
module bsg_blank_timer
    import bsg_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw,
    input  logic [DLY_W-1:0] delay,
    input  logic [LEN_W-1:0] len,
    output logic             blank
);
    localparam int CW = (DLY_W > LEN_W) ? DLY_W : LEN_W;

    blk_phase_e    phase_q;
    logic [CW-1:0] cnt_q;
    logic          sw_q;
    logic          edge_seen;

    assign edge_seen = sw ^ sw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= BLK_IDLE;
            cnt_q   <= '0;
            sw_q    <= 1'b0;
        end else begin
            sw_q <= sw;
            if (edge_seen) begin
                if (delay != '0) begin
                    phase_q <= BLK_DELAY;
                    cnt_q   <= CW'(delay);
                end else if (len != '0) begin
                    phase_q <= BLK_ACTIVE;
                    cnt_q   <= CW'(len);
                end else begin
                    phase_q <= BLK_IDLE;
                    cnt_q   <= '0;
                end
            end else begin
                case (phase_q)
                    BLK_DELAY: begin
                        if (cnt_q == CW'(1)) begin
                            if (len != '0) begin
                                phase_q <= BLK_ACTIVE;
                                cnt_q   <= CW'(len);
                            end else begin
                                phase_q <= BLK_IDLE;
                                cnt_q   <= '0;
                            end
                        end else begin
                            cnt_q <= cnt_q - CW'(1);
                        end
                    end
                    BLK_ACTIVE: begin
                        if (cnt_q == CW'(1)) begin
                            phase_q <= BLK_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q - CW'(1);
                        end
                    end
                    default: begin
                        phase_q <= BLK_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    assign blank = (phase_q == BLK_ACTIVE);

endmodule

// File: rtl/bsg_glitch_counter.sv
module bsg_glitch_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (inc && !(&count_q)) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/bitstream_gate.sv
module bitstream_gate
    import bsg_pkg::*;
#(
    parameter int RUN_W = 8,
    parameter int DLY_W = 8,
    parameter int LEN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              sw_evt,
    input  logic [MINW_W-1:0] cfg_min_width,
    input  logic [RUN_W-1:0]  cfg_max_run,
    input  logic [DLY_W-1:0]  cfg_blank_delay,
    input  logic [LEN_W-1:0]  cfg_blank_len,
    input  logic              cnt_clear,
    output logic              bit_out,
    output logic              bit_flag,
    output logic              sat_flag,
    output logic [CNT_W-1:0]  glitch_count
);
    filt_out_t filt;
    logic      blank_q;
    logic      held_q;

    bsg_pulse_filter u_filt (
        .clk       (clk),
        .rst       (rst),
        .din       (bit_in),
        .min_width (cfg_min_width),
        .fout      (filt)
    );

    bsg_run_monitor #(.RUN_W(RUN_W)) u_run (
        .clk     (clk),
        .rst     (rst),
        .din     (bit_in),
        .max_run (cfg_max_run),
        .sat     (sat_flag)
    );

    bsg_blank_timer #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_blank (
        .clk   (clk),
        .rst   (rst),
        .sw    (sw_evt),
        .delay (cfg_blank_delay),
        .len   (cfg_blank_len),
        .blank (blank_q)
    );

    bsg_glitch_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .inc   (filt.reject),
        .count (glitch_count)
    );

    // last delivered bit, replayed while blanked
    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= bit_out;
    end

    assign bit_out  = blank_q ? held_q : filt.level;
    assign bit_flag = blank_q | filt.pending;

endmodule

// File: rtl/bitstream_gate_chk.sv
module bitstream_gate_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_in,
    input logic             bit_out,
    input logic             bit_flag,
    input logic             blank,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] glitch_count
);
    // R9
    blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (blank && $past(blank)) |-> (bit_out == $past(bit_out)));

    // R2
    out_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        (!blank && !$past(blank) && (bit_out != $past(bit_out))) |-> (bit_out == $past(bit_in)));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clear |=> (glitch_count == '0));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_clear |=> ((glitch_count >= $past(glitch_count)) &&
                        ((CNT_W+1)'(glitch_count) <= (CNT_W+1)'($past(glitch_count)) + (CNT_W+1)'(1))));

    // R4
    count_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (glitch_count > $past(glitch_count)) |-> $past(bit_flag));

endmodule

bind bitstream_gate bitstream_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_in       (bit_in),
    .bit_out      (bit_out),
    .bit_flag     (bit_flag),
    .blank        (blank_q),
    .cnt_clear    (cnt_clear),
    .glitch_count (glitch_count)
);

// File: tb/sim_bitstream_gate.sv
module sim_bitstream_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_in = 1'b0;
    logic        sw_evt = 1'b0;
    logic        cnt_clear = 1'b0;
    logic [2:0]  min_w = 3'd1;
    logic [7:0]  max_run = 8'd255;
    logic [7:0]  bdly = 8'd0;
    logic [7:0]  blen = 8'd0;
    logic        bit_out, bit_flag, sat_flag;
    logic [15:0] glitch_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bitstream_gate u0 (
        .clk             (clk),
        .rst             (rst),
        .bit_in          (bit_in),
        .sw_evt          (sw_evt),
        .cfg_min_width   (min_w),
        .cfg_max_run     (max_run),
        .cfg_blank_delay (bdly),
        .cfg_blank_len   (blen),
        .cnt_clear       (cnt_clear),
        .bit_out         (bit_out),
        .bit_flag        (bit_flag),
        .sat_flag        (sat_flag),
        .glitch_count    (glitch_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive before an edge, then look 1 ns after it
    task automatic tick(input logic b);
        bit_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_glitch();
        tick(1'b1);
        tick(1'b0);
    endtask

    initial begin
        logic [15:0] c0;
        int          g;
        repeat (3) @(posedge clk);
        #1;
        check("R1 bit_out", 32'(bit_out), 0);
        check("R1 bit_flag", 32'(bit_flag), 0);
        check("R1 sat_flag", 32'(sat_flag), 0);
        check("R1 glitch_count", 32'(glitch_count), 0);
        rst = 1'b0;
        tick(1'b0);
        check("R1 first cycle out", 32'(bit_out), 0);
        check("R1 first cycle count", 32'(glitch_count), 0);

        // pulse width sweep: every min width against every pulse width
        g = 0;
        for (int n = 1; n <= 7; n++) begin
            min_w = 3'(n);
            for (int w = 1; w <= 7; w++) begin
                repeat (10) tick(1'b0);
                c0 = glitch_count;
                for (int k = 1; k <= w; k++) begin
                    tick(1'b1);
                    if (k < n) begin
                        check("R3 flag while qualifying", 32'(bit_flag), 1);
                        check("R3 hold while qualifying", 32'(bit_out), 0);
                    end else if (k == n) begin
                        check("R2 accepted at Nth edge", 32'(bit_out), 1);
                        check("R2 flag after accept", 32'(bit_flag), 0);
                    end
                end
                tick(1'b0);
                if (w < n) begin
                    g++;
                    check("R4 short pulse rejected", 32'(bit_out), 0);
                    check("R4 glitch counted", 32'(glitch_count), 32'(c0) + 1);
                end else begin
                    check("R4 legal pulse not counted", 32'(glitch_count), 32'(c0));
                end
                repeat (9) tick(1'b0);
            end
        end
        check("R4 total glitch count", 32'(glitch_count), 32'(g));

        // width 0 behaves as 1
        min_w = 3'd0;
        repeat (4) tick(1'b0);
        tick(1'b1);
        check("R2 zero width as one", 32'(bit_out), 1);
        tick(1'b0);
        check("R2 zero width return", 32'(bit_out), 0);

        // clear versus simultaneous glitch
        min_w = 3'd3;
        cnt_clear = 1'b1;
        tick(1'b0);
        cnt_clear = 1'b0;
        check("R6 clear", 32'(glitch_count), 0);
        tick(1'b1);
        cnt_clear = 1'b1;
        tick(1'b0);
        cnt_clear = 1'b0;
        check("R6 clear wins over glitch", 32'(glitch_count), 0);
        pulse_glitch();
        check("R6 counting after clear", 32'(glitch_count), 1);

        // saturation of the counter
        min_w = 3'd2;
        cnt_clear = 1'b1;
        tick(1'b0);
        cnt_clear = 1'b0;
        for (int i = 1; i <= 65538; i++) begin
            pulse_glitch();
            if (i == 65534) check("R5 below max", 32'(glitch_count), 65534);
        end
        check("R5 saturated", 32'(glitch_count), 65535);
        cnt_clear = 1'b1;
        tick(1'b0);
        cnt_clear = 1'b0;
        check("R6 clear from max", 32'(glitch_count), 0);

        // run-length monitor
        min_w = 3'd1;
        for (int m = 1; m <= 6; m++) begin
            max_run = 8'(m);
            tick(1'b0);
            for (int k = 1; k <= m + 2; k++) begin
                tick(1'b1);
                check("R7 run flag", 32'(sat_flag), (k > m) ? 1 : 0);
            end
            tick(1'b0);
            check("R7 run restarts", 32'(sat_flag), 0);
        end
        max_run = 8'd255;

        // blanking window placement and hold
        for (int d = 0; d <= 3; d++) begin
            for (int l = 1; l <= 4; l++) begin
                bdly = 8'(d);
                blen = 8'(l);
                repeat (4) tick(1'b0);
                sw_evt = ~sw_evt;
                for (int j = 0; j <= d + l + 1; j++) begin
                    tick((j >= d) ? 1'b1 : 1'b0);
                    check("R8 window flag", 32'(bit_flag), (j >= d && j < d + l) ? 1 : 0);
                    check("R9 output held in window", 32'(bit_out), (j >= d + l) ? 1 : 0);
                end
                repeat (4) tick(1'b0);
            end
        end

        // zero length: no window
        bdly = 8'd0;
        blen = 8'd0;
        sw_evt = ~sw_evt;
        for (int j = 0; j < 5; j++) begin
            tick(1'b0);
            check("R8 zero length", 32'(bit_flag), 0);
        end

        // restart by a second edge
        bdly = 8'd2;
        blen = 8'd4;
        repeat (4) tick(1'b0);
        for (int j = 0; j <= 10; j++) begin
            if (j == 0 || j == 3) sw_evt = ~sw_evt;
            tick(1'b0);
            check("R10 restart", 32'(bit_flag), (j == 2 || (j >= 5 && j < 9)) ? 1 : 0);
        end

        // window and qualification on the same bit
        min_w = 3'd3;
        bdly = 8'd0;
        blen = 8'd2;
        repeat (6) tick(1'b0);
        sw_evt = ~sw_evt;
        tick(1'b1);
        check("R9 overlap hold j0", 32'(bit_out), 0);
        check("R3 overlap flag j0", 32'(bit_flag), 1);
        tick(1'b1);
        check("R9 overlap hold j1", 32'(bit_out), 0);
        check("R3 overlap flag j1", 32'(bit_flag), 1);
        tick(1'b1);
        check("R2 overlap release", 32'(bit_out), 1);
        check("R3 overlap flag clear", 32'(bit_flag), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule